// File: doc/BRIEF.md
# Multi-lane deskew aligner

The aligner sits behind one to four byte-framed receive lanes of a high-speed serial link. Each lane already has its own byte framer, which presents one byte per byte clock and a per-lane sync flag. The flag rises in the cycle that carries the lane's start-of-transmission sync byte. The same sync byte goes out on every lane one byte time before the packet header. Board and receiver skew can make the lanes reach sync up to a few byte clocks apart.

The block records the cycle in which each lane's sync flag rose. Each lane then passes through a short delay line whose tap equals the gap between the latest arrival and that lane's own arrival. The sync bytes, and every payload byte after them, therefore leave all lanes in the same output cycle, and one combined sync output is raised. If the lanes do not all arrive within the skew window, an alignment error is raised instead. Dropping the high-speed enable clears everything, and the next burst is aligned anew.

A build option bypasses the alignment and leaves the framed lanes unchanged. A single-lane build behaves the same way. All outputs are registered.

Top module: `lane_deskew_aligner`

## Requirements
- R1: While `rst_n` is low, `lane_data_o`, `all_sync_o` and `align_err_o` are all 0, whatever the inputs are.
- R2: Lane k uses bits [8k+7:8k] of the data buses and bit k of `lane_sync_i`. The cycle in which bit k first rises carries lane k's sync byte. Let T be the cycle in which the last lane's flag rises, and suppose every lane rose no more than 4 cycles after the first. Then `all_sync_o` is 1 in cycle T+1, and in that cycle every lane of `lane_data_o` shows its own sync byte.
- R3: After the lock of R2, the n-th byte following the sync byte on every lane appears on `lane_data_o` in cycle T+1+n, on all lanes in the same cycle. The last-arriving lane therefore has one cycle of latency, and each earlier lane is delayed further by its arrival difference.
- R4: Let F be the cycle in which the first lane's flag rises. If some lane has not risen by cycle F+4, `align_err_o` is 1 from cycle F+5 and `all_sync_o` stays 0. Sync flags that rise later do not change either output.
- R5: Once `all_sync_o` or `align_err_o` is 1, it stays 1 for as long as `hs_enable` stays high.
- R6: When `hs_enable` is 0 in a cycle, `all_sync_o` and `align_err_o` are 0 in the next cycle. Sync flags seen while `hs_enable` is low have no effect. The next burst is aligned from scratch, with its own skew.
- R7: `all_sync_o` and `align_err_o` are never 1 in the same cycle.
- R8: With `BYPASS` set, `lane_data_o` equals `lane_data_i` one cycle later, regardless of skew. `all_sync_o` is the registered AND of `hs_enable` with all lane flags, and `align_err_o` is 0.
- R9: With `NUM_LANES` = 1, the lane is forwarded with only the output register as latency, and `all_sync_o` is the registered AND of `hs_enable` with that lane's flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_enable | input | 1 | High-speed burst enable; low clears the alignment |
| lane_data_i | input | NUM_LANES*BYTE_W | Framed bytes from each lane, lane k at bits [BYTE_W*k +: BYTE_W] |
| lane_sync_i | input | NUM_LANES | Per-lane framed flag; bit k rises with lane k's sync byte |
| lane_data_o | output | NUM_LANES*BYTE_W | Deskewed bytes, same lane layout |
| all_sync_o | output | 1 | All lanes mutually aligned |
| align_err_o | output | 1 | Lanes did not all arrive within the skew window |

## Verification
The two functions that can fall in the same cycle are the lock of the last lane and the expiry of the skew window. When a lane arrives exactly 4 cycles after the first, the cycle that would expire the window is also the cycle that completes the arrival set. The bench provokes this with arrival offsets {3,0,4,1} and judges that lock wins: the sync bytes line up and no error is raised. It then uses offsets {0,5,1,2}, and expects the error one cycle later with the late arrival ignored. A second coincidence is an enable drop in the same cycle as a set of sync flags. The bench checks that the flags are discarded and that the next burst realigns with a different skew.

// File: rtl/lane_deskew_pkg.sv
package lane_deskew_pkg;

   typedef enum logic [1:0] {
      AL_IDLE   = 2'd0,
      AL_GATHER = 2'd1,
      AL_LOCKED = 2'd2,
      AL_FAULT  = 2'd3
   } align_state_e;

   // Width of an arrival offset that spans 0..max_skew
   function automatic int unsigned off_width(input int unsigned max_skew);
      return (max_skew < 1) ? 1 : $clog2(max_skew + 1);
   endfunction

endpackage

// File: rtl/lane_delay_line.sv
module lane_delay_line
   import lane_deskew_pkg::*;
#(
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned MAX_SKEW = 4,
   parameter int unsigned OFF_W    = off_width(MAX_SKEW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] din_i,
   input  logic [OFF_W-1:0]  sel_i,
   output logic [BYTE_W-1:0] dout_o
);
   localparam int unsigned NTAP = MAX_SKEW + 1;
   localparam logic [OFF_W-1:0] TOP_TAP = OFF_W'(MAX_SKEW);

   logic [BYTE_W-1:0] stage_q [MAX_SKEW];
   logic [BYTE_W-1:0] tap     [NTAP];

   // tap j holds the byte that arrived j cycles ago
   assign tap[0] = din_i;
   for (genvar j = 1; j < NTAP; j++) begin : g_tap
      assign tap[j] = stage_q[j-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int j = 0; j < MAX_SKEW; j++) stage_q[j] <= '0;
         dout_o <= '0;
      end else begin
         stage_q[0] <= din_i;
         for (int j = 1; j < MAX_SKEW; j++) stage_q[j] <= stage_q[j-1];
         dout_o <= (sel_i <= TOP_TAP) ? tap[sel_i] : tap[0];
      end
   end

endmodule

// File: rtl/lane_skew_tracker.sv
module lane_skew_tracker
   import lane_deskew_pkg::*;
#(
   parameter int unsigned NUM_LANES = 4,
   parameter int unsigned MAX_SKEW  = 4,
   parameter int unsigned OFF_W     = off_width(MAX_SKEW)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       hs_enable,
   input  logic [NUM_LANES-1:0]       sync_i,
   output logic [NUM_LANES*OFF_W-1:0] sel_o,
   output logic                       locked_o,
   output logic                       fault_o
);
   localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(MAX_SKEW);

   align_state_e         state_q;
   logic [OFF_W-1:0]     cnt_q;
   logic [OFF_W-1:0]     cur_off;
   logic [NUM_LANES-1:0] seen_q;
   logic [NUM_LANES-1:0] arrived;
   logic [OFF_W-1:0]     arr_q   [NUM_LANES];
   logic [OFF_W-1:0]     dly_q   [NUM_LANES];
   logic [OFF_W-1:0]     dly_now [NUM_LANES];
   logic                 hunting;
   logic                 all_in;
   logic                 any_in;
   logic                 lock_now;

   always_comb begin
      hunting  = (state_q == AL_IDLE) || (state_q == AL_GATHER);
      cur_off  = (state_q == AL_GATHER) ? cnt_q : '0;
      arrived  = seen_q | sync_i;
      all_in   = &arrived;
      any_in   = |arrived;
      lock_now = hs_enable && hunting && all_in;
   end

   // a lane arriving now has offset cur_off; its delay is latest minus own
   for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
      assign dly_now[k] = cur_off - (seen_q[k] ? arr_q[k] : cur_off);
      assign sel_o[k*OFF_W +: OFF_W] = lock_now ? dly_now[k] : dly_q[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= AL_IDLE;
         cnt_q    <= '0;
         seen_q   <= '0;
         locked_o <= 1'b0;
         fault_o  <= 1'b0;
         for (int k = 0; k < NUM_LANES; k++) begin
            arr_q[k] <= '0;
            dly_q[k] <= '0;
         end
      end else if (!hs_enable) begin
         state_q  <= AL_IDLE;
         cnt_q    <= '0;
         seen_q   <= '0;
         locked_o <= 1'b0;
         fault_o  <= 1'b0;
         for (int k = 0; k < NUM_LANES; k++) begin
            arr_q[k] <= '0;
            dly_q[k] <= '0;
         end
      end else if (hunting) begin
         for (int k = 0; k < NUM_LANES; k++) begin
            if (sync_i[k] && !seen_q[k]) begin
               seen_q[k] <= 1'b1;
               arr_q[k]  <= cur_off;
            end
         end
         if (all_in) begin
            state_q  <= AL_LOCKED;
            locked_o <= 1'b1;
            for (int k = 0; k < NUM_LANES; k++) dly_q[k] <= dly_now[k];
         end else if (any_in) begin
            if (cur_off == LAST_OFF) begin
               state_q <= AL_FAULT;
               fault_o <= 1'b1;
            end else begin
               state_q <= AL_GATHER;
               cnt_q   <= cur_off + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/lane_deskew_aligner.sv
module lane_deskew_aligner
   import lane_deskew_pkg::*;
#(
   parameter int unsigned NUM_LANES = 4,
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned MAX_SKEW  = 4,
   parameter bit          BYPASS    = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        hs_enable,
   input  logic [NUM_LANES*BYTE_W-1:0] lane_data_i,
   input  logic [NUM_LANES-1:0]        lane_sync_i,
   output logic [NUM_LANES*BYTE_W-1:0] lane_data_o,
   output logic                        all_sync_o,
   output logic                        align_err_o
);
   localparam int unsigned OFF_W     = off_width(MAX_SKEW);
   localparam bit          PASS_MODE = BYPASS || (NUM_LANES == 1);

   if ((NUM_LANES < 1) || (NUM_LANES > 4)) begin : g_bad_lanes
      $error("lane_deskew_aligner: NUM_LANES must be 1..4");
   end
   if (BYTE_W < 1) begin : g_bad_width
      $error("lane_deskew_aligner: BYTE_W must be at least 1");
   end
   if (MAX_SKEW < 1) begin : g_bad_skew
      $error("lane_deskew_aligner: MAX_SKEW must be at least 1");
   end

   if (PASS_MODE) begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lane_data_o <= '0;
            all_sync_o  <= 1'b0;
         end else begin
            lane_data_o <= lane_data_i;
            all_sync_o  <= hs_enable && (&lane_sync_i);
         end
      end
      assign align_err_o = 1'b0;
   end else begin : g_align
      logic [NUM_LANES*OFF_W-1:0] sel;

      lane_skew_tracker #(
         .NUM_LANES (NUM_LANES),
         .MAX_SKEW  (MAX_SKEW),
         .OFF_W     (OFF_W)
      ) trk_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .hs_enable (hs_enable),
         .sync_i    (lane_sync_i),
         .sel_o     (sel),
         .locked_o  (all_sync_o),
         .fault_o   (align_err_o)
      );

      for (genvar k = 0; k < NUM_LANES; k++) begin : g_dl
         lane_delay_line #(
            .BYTE_W   (BYTE_W),
            .MAX_SKEW (MAX_SKEW),
            .OFF_W    (OFF_W)
         ) dl_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .din_i  (lane_data_i[k*BYTE_W +: BYTE_W]),
            .sel_i  (sel[k*OFF_W +: OFF_W]),
            .dout_o (lane_data_o[k*BYTE_W +: BYTE_W])
         );
      end
   end

endmodule

// File: rtl/lane_deskew_chk.sv
module lane_deskew_chk #(
   parameter int unsigned NUM_LANES = 4,
   parameter int unsigned BYTE_W    = 8,
   parameter bit          PASS_MODE = 1'b0
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        hs_enable,
   input logic [NUM_LANES*BYTE_W-1:0] lane_data_i,
   input logic [NUM_LANES-1:0]        lane_sync_i,
   input logic [NUM_LANES*BYTE_W-1:0] lane_data_o,
   input logic                        all_sync_o,
   input logic                        align_err_o
);
   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R6
   hs_drop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hs_enable |=> (!all_sync_o && !align_err_o));

   if (PASS_MODE) begin : g_pass_chk
      // R8 R9
      pass_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok |-> (lane_data_o == $past(lane_data_i)));
      // R8 R9
      pass_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(all_sync_o) |-> ($past(&lane_sync_i) && $past(hs_enable)));
   end else begin : g_align_chk
      // R7
      sync_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(all_sync_o && align_err_o));
      // R5
      lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (all_sync_o && hs_enable) |=> all_sync_o);
      // R5
      err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (align_err_o && hs_enable) |=> align_err_o);
      // R2
      lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(all_sync_o) |-> ($past(hs_enable) && $past(|lane_sync_i)));
   end

endmodule

bind lane_deskew_aligner lane_deskew_chk #(
   .NUM_LANES (NUM_LANES),
   .BYTE_W    (BYTE_W),
   .PASS_MODE (BYPASS || (NUM_LANES == 1))
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .hs_enable   (hs_enable),
   .lane_data_i (lane_data_i),
   .lane_sync_i (lane_sync_i),
   .lane_data_o (lane_data_o),
   .all_sync_o  (all_sync_o),
   .align_err_o (align_err_o)
);

// File: tb/lane_deskew_aligner_tb_top.sv
`timescale 1ns/1ps
module lane_deskew_aligner_tb_top;
   localparam logic [7:0] SYNC_B = 8'hB8;

   logic        clk   = 1'b0;
   logic        rst_n = 1'b0;
   logic        hs    = 1'b0;
   logic [3:0]  sv    = '0;
   logic [31:0] dv    = '0;

   logic [31:0] m_do, p_do;
   logic [7:0]  o_do;
   logic        m_sy, m_er, p_sy, p_er, o_sy, o_er;

   always #2.5 clk = ~clk;

   lane_deskew_aligner dut_i (
      .clk(clk), .rst_n(rst_n), .hs_enable(hs), .lane_data_i(dv), .lane_sync_i(sv),
      .lane_data_o(m_do), .all_sync_o(m_sy), .align_err_o(m_er));

   lane_deskew_aligner #(.BYPASS(1'b1)) dut_pass_i (
      .clk(clk), .rst_n(rst_n), .hs_enable(hs), .lane_data_i(dv), .lane_sync_i(sv),
      .lane_data_o(p_do), .all_sync_o(p_sy), .align_err_o(p_er));

   lane_deskew_aligner #(.NUM_LANES(1)) dut_one_i (
      .clk(clk), .rst_n(rst_n), .hs_enable(hs), .lane_data_i(dv[7:0]), .lane_sync_i(sv[0]),
      .lane_data_o(o_do), .all_sync_o(o_sy), .align_err_o(o_er));

   typedef struct {
      int          cyc;
      int          which;
      bit          chk_data;
      logic [31:0] data;
      logic        sync;
      logic        err;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   exp_t it;
   int   cyc     = 0;
   int   n_tests = 0;
   int   n_fail  = 0;
   bit   done    = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [7:0] pay(int k, int n);
      return 8'((k << 6) | (n & 63));
   endfunction

   function automatic void push_exp(int c, int w, bit cd, logic [31:0] d, logic s, logic e,
                                    string t);
      exp_t x;
      x.cyc = c; x.which = w; x.chk_data = cd; x.data = d; x.sync = s; x.err = e; x.tag = t;
      exp_q.push_back(x);
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   // driver: apply one cycle of stimulus and queue what every instance must show next cycle
   task automatic drive_cycle(input logic h, input logic [3:0] s, input logic [31:0] d,
                              input bit m_on, input bit m_cd, input logic [31:0] m_d,
                              input logic m_s, input logic m_e, input string tag);
      @(posedge clk); #1;
      hs = h; sv = s; dv = d;
      if (m_on) push_exp(cyc + 1, 0, m_cd, m_d, m_s, m_e, tag);
      push_exp(cyc + 1, 1, 1'b1, d, h & (&s), 1'b0, "R8 bypass");
      push_exp(cyc + 1, 2, 1'b1, {24'h0, d[7:0]}, h & s[0], 1'b0, "R9 single lane");
   endtask

   task automatic run_burst(input int off[4], input int len, input bit ok, input string tag);
      int maxo;
      maxo = 0;
      for (int k = 0; k < 4; k++) if (off[k] > maxo && off[k] < 50) maxo = off[k];
      drive_cycle(1'b1, 4'h0, 32'hE3E2E1E0, 1'b1, 1'b0, '0, 1'b0, 1'b0, {tag, " R2 lead-in"});
      for (int i = 0; i < len; i++) begin
         logic [3:0]  s;
         logic [31:0] d;
         logic [31:0] e;
         logic        es, ee;
         bit          cd;
         string       t;
         for (int k = 0; k < 4; k++) begin
            int idx;
            idx = i - off[k];
            if (idx < 0) begin
               s[k] = 1'b0; d[k*8 +: 8] = 8'hE0 + 8'(k);
            end else if (idx == 0) begin
               s[k] = 1'b1; d[k*8 +: 8] = SYNC_B;
            end else begin
               s[k] = 1'b1; d[k*8 +: 8] = pay(k, idx);
            end
         end
         e = '0;
         if (ok) begin
            es = (i >= maxo); ee = 1'b0; cd = es;
            for (int k = 0; k < 4; k++)
               e[k*8 +: 8] = (i == maxo) ? SYNC_B : pay(k, i - maxo);
            t = (i == maxo) ? {tag, " R2 R7"} : {tag, " R3 R5 R7"};
         end else begin
            es = 1'b0; ee = (i >= 4); cd = 1'b0;
            t = {tag, " R4 R5 R7"};
         end
         drive_cycle(1'b1, s, d, 1'b1, cd, e, es, ee, t);
      end
      drive_cycle(1'b0, 4'h0, '0, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R6 enable drop");
      drive_cycle(1'b0, 4'h0, '0, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R6 enable drop");
   endtask

   // monitor: pop expectations due this cycle and compare
   always @(negedge clk) begin
      while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
         logic [31:0] ad;
         logic        as_, ae;
         it = exp_q.pop_front();
         case (it.which)
            0:       begin ad = m_do;           as_ = m_sy; ae = m_er; end
            1:       begin ad = p_do;           as_ = p_sy; ae = p_er; end
            default: begin ad = {24'h0, o_do}; as_ = o_sy; ae = o_er; end
         endcase
         n_tests++;
         if (it.cyc != cyc || as_ !== it.sync || ae !== it.err ||
             (it.chk_data && ad !== it.data)) begin
            n_fail++;
            $display("FAIL %s: inst=%0d cyc=%0d data=%h exp %h sync=%b exp %b err=%b exp %b",
                     it.tag, it.which, cyc, ad, it.data, as_, it.sync, ae, it.err);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog R1: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      hs = 1'b1; sv = 4'hF; dv = 32'hFFFF_FFFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset dominates the inputs
      check(m_do == '0 && o_do == '0 && p_do == '0, "R1 reset data", {m_do}, 32'h0);
      check(!m_sy && !p_sy && !o_sy, "R1 reset sync", {31'h0, m_sy}, 32'h0);
      check(!m_er, "R1 reset err", {31'h0, m_er}, 32'h0);
      hs = 1'b0; sv = 4'h0; dv = '0;
      @(posedge clk); #1 rst_n = 1'b1;

      run_burst('{0, 0, 0, 0}, 6, 1'b1, "no skew");
      run_burst('{0, 2, 1, 3}, 8, 1'b1, "mixed skew");
      run_burst('{3, 0, 4, 1}, 9, 1'b1, "boundary skew 4");
      run_burst('{0, 5, 1, 2}, 9, 1'b0, "lane late by 5");
      // R6 sync flags while disabled are ignored
      drive_cycle(1'b0, 4'hF, {4{SYNC_B}}, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R6 ignored while disabled");
      drive_cycle(1'b0, 4'h0, '0, 1'b1, 1'b0, '0, 1'b0, 1'b0, "R6 ignored while disabled");
      run_burst('{0, 1, 99, 2}, 8, 1'b0, "lane missing");
      run_burst('{2, 0, 0, 1}, 7, 1'b1, "R6 realign after fault");

      repeat (3) @(posedge clk);
      @(negedge clk);
      check(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 32'h0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule